// File: doc/BRIEF.md
# Dual-Convention Host Control Port with Configuration Register Bank

This block links an asynchronous 8-bit host bus to a bank of 64 byte-wide configuration registers that run on the core clock. The host uses a 6-bit address, a byte of write data, a byte of read data and three active-low lines: a select, a read line and a write line. The block drives an output-enable for an external tri-state pad cell. That enable follows the host lines combinationally, so the bus is released as soon as the host ends a read. Read data comes straight from the addressed register.

Two strobe conventions share the same pins and need no mode pin. In the split convention, the read line and the write line each frame their own transfer while the select is low. In the direction convention, the read line is tied low, the write line gives the direction (high reads, low writes), and the select alone times the transfer. In both conventions a write is the select and the write line low together. The select and write lines pass through two-flop synchronisers. Each core-clock edge on which the synchronised write is active captures the address and data into a holding stage. The write is committed once, when the synchronised write goes inactive.

The host must hold the address and data for at least two core-clock edges after it ends a write. A committed value is visible in the bank from the third rising edge after the release. The whole bank is also exposed as a flat vector to the core logic.

Top module: `ctlbus_regfile`

## Requirements
- R1: `bus_oe` is 1 in the same cycle exactly when `bus_cs_n`=0, `bus_rd_n`=0 and `bus_wr_n`=1.
- R2: `bus_oe` is 0 for each of the other seven combinations of (`bus_cs_n`, `bus_rd_n`, `bus_wr_n`), including the one with read and write both low.
- R3: While `bus_oe` is 1, `bus_dout` equals register `bus_addr`. While it is 0, `bus_dout` is 8'h00.
- R4: Split convention: a transfer with `bus_cs_n`=0, `bus_wr_n`=0 and `bus_rd_n`=1 stores `bus_din` in register `bus_addr`. The value is readable from the third rising clock edge after the select and write lines return high.
- R5: Direction convention: with `bus_rd_n` held 0, a transfer with `bus_wr_n`=0 and a `bus_cs_n` low pulse stores the byte in the same way. A read in this convention (`bus_wr_n`=1) returns the stored byte.
- R6: The stored value is the address and data present at the last edge before release. Changes to `bus_addr` or `bus_din` made two or more edges after release have no effect.
- R7: A low `bus_wr_n` while `bus_cs_n` is 1 changes no register.
- R8: A read transfer changes no register.
- R9: `rst_n`=0 clears all 64 registers to 8'h00 (both `cfg_q` and reads show 0).
- R10: `cfg_q[8*i+7:8*i]` holds register i.
- R11: One write transfer commits exactly once and changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cs_n | input | 1 | Host select, active low |
| bus_rd_n | input | 1 | Host read line, active low |
| bus_wr_n | input | 1 | Host write line, active low (direction bit in the direction convention) |
| bus_addr | input | 6 | Register address |
| bus_din | input | 8 | Write data from the pad |
| bus_dout | output | 8 | Read data to the pad |
| bus_oe | output | 1 | Pad output enable, high drives the bus |
| cfg_q | output | 512 | All registers, register i in bits 8*i+7:8*i |

## Verification
A host read and a pending write commit can land in the same cycle. For example, the direction convention lets the write line rise with the select still low, which turns a write into a read of the same address while the synchronised commit is still in flight. The bench provokes the same overlap in another way: it sweeps all eight line combinations on one address, so a write qualification is raised next to reads. The written byte is chosen to equal the register's current contents. The bench then reads the address back and checks that it kept that value and that no other register changed. The bound assertions add that each commit lasts one cycle, lands its own byte, and leaves the bank untouched in every other cycle.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;
  localparam int unsigned CB_ADDR_W = 6;
  localparam int unsigned CB_DATA_W = 8;
  localparam int unsigned CB_SYNC_STAGES = 2;
endpackage

// File: rtl/ctlbus_rst_sync.sv
module ctlbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] rst_pipe_q;
  logic [1:0] rst_pipe_d;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_sync_n = rst_pipe_q[1];
endmodule

// File: rtl/ctlbus_sync.sv
module ctlbus_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = ctlbus_pkg::CB_SYNC_STAGES,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ctlbus_wr_cmd.sv
module ctlbus_wr_cmd #(
  parameter int unsigned AW = ctlbus_pkg::CB_ADDR_W,
  parameter int unsigned DW = ctlbus_pkg::CB_DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s_n,
  input  logic          wr_s_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic          commit,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  logic          qual_now;
  logic          qual_q, qual_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          hold_en;

  always_comb begin
    qual_now = !cs_s_n && !wr_s_n;
    hold_en  = qual_now;
    qual_d   = qual_now;
    addr_d   = addr_q;
    data_d   = data_q;
    if (hold_en) begin
      addr_d = bus_addr;
      data_d = bus_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      qual_q <= qual_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign commit   = qual_q && !qual_now;
  assign cmd_addr = addr_q;
  assign cmd_data = data_q;
endmodule

// File: rtl/ctlbus_regbank.sv
module ctlbus_regbank #(
  parameter int unsigned AW = ctlbus_pkg::CB_ADDR_W,
  parameter int unsigned DW = ctlbus_pkg::CB_DATA_W,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic [AW-1:0]       raddr,
  output logic [DW-1:0]       rdata,
  output logic [DEPTH*DW-1:0] cfg_q
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic          row_en [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_comb begin
      row_en[i] = we && (waddr == AW'(i));
      mem_d[i]  = row_en[i] ? wdata : mem_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else        mem_q[i] <= mem_d[i];
    end

    assign cfg_q[i*DW +: DW] = mem_q[i];
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/ctlbus_regfile.sv
module ctlbus_regfile #(
  parameter int unsigned ADDR_W = ctlbus_pkg::CB_ADDR_W,
  parameter int unsigned DATA_W = ctlbus_pkg::CB_DATA_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_cs_n,
  input  logic                    bus_rd_n,
  input  logic                    bus_wr_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_din,
  output logic [DATA_W-1:0]       bus_dout,
  output logic                    bus_oe,
  output logic [DEPTH*DATA_W-1:0] cfg_q
);
  logic              rst_sync_n;
  logic [1:0]        strobe_s;
  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  ctlbus_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // bit 1: select, bit 0: write line; both idle high
  ctlbus_sync #(.WIDTH(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({bus_cs_n, bus_wr_n}),
    .q     (strobe_s)
  );

  ctlbus_wr_cmd #(.AW(ADDR_W), .DW(DATA_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_s_n   (strobe_s[1]),
    .wr_s_n   (strobe_s[0]),
    .bus_addr (bus_addr),
    .bus_din  (bus_din),
    .commit   (wr_commit),
    .cmd_addr (wr_addr),
    .cmd_data (wr_data)
  );

  ctlbus_regbank #(.AW(ADDR_W), .DW(DATA_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (wr_commit),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (bus_addr),
    .rdata (rd_data),
    .cfg_q (cfg_q)
  );

  // Drive qualification taken straight from the pins so release is immediate.
  assign bus_oe   = !bus_cs_n && !bus_rd_n && bus_wr_n;
  assign bus_dout = bus_oe ? rd_data : '0;
endmodule

// File: rtl/ctlbus_regfile_chk.sv
module ctlbus_regfile_chk #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_oe,
  input logic [DW-1:0]       bus_dout,
  input logic [DEPTH*DW-1:0] cfg_q,
  input logic                wr_commit,
  input logic [AW-1:0]       wr_addr,
  input logic [DW-1:0]       wr_data
);
  assert_dout_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_dout == '0));

  assert_commit_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  assert_commit_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (cfg_q[int'($past(wr_addr))*DW +: DW] == $past(wr_data)));

  assert_bank_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(cfg_q));
endmodule

bind ctlbus_regfile ctlbus_regfile_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_oe    (bus_oe),
  .bus_dout  (bus_dout),
  .cfg_q     (cfg_q),
  .wr_commit (wr_commit),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/ctlbus_regfile_tb.sv
module ctlbus_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {alt(1), addr(6), data(8)}
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 6'd0,  8'hA5}, {1'b1, 6'd1,  8'h3C}, {1'b0, 6'd63, 8'hFF},
    {1'b1, 6'd32, 8'h01}, {1'b0, 6'd17, 8'h80}, {1'b1, 6'd42, 8'h7E},
    {1'b0, 6'd5,  8'h5A}, {1'b1, 6'd6,  8'hC3}};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_cs_n, bus_rd_n, bus_wr_n;
  logic [5:0]  bus_addr;
  logic [7:0]  bus_din;
  logic [7:0]  bus_dout;
  logic        bus_oe;
  logic [511:0] cfg_q;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [64];

  ctlbus_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .cfg_q(cfg_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
  endtask

  task automatic do_write(input bit alt, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_din = d; bus_rd_n = alt ? 1'b0 : 1'b1; bus_wr_n = 1'b0;
    @(negedge clk); bus_cs_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_cs_n = 1'b1;
    if (!alt) bus_wr_n = 1'b1;
    @(negedge clk);
    idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input bit alt, input logic [5:0] a,
                         output logic oe, output logic [7:0] q);
    @(negedge clk);
    bus_addr = a; bus_wr_n = 1'b1; bus_rd_n = 1'b0;
    if (!alt) begin @(negedge clk); end
    bus_cs_n = 1'b0;
    #1; oe = bus_oe; q = bus_dout;
    @(negedge clk); idle();
  endtask

  task automatic check_bank(input string req);
    logic bad = 1'b0;
    for (int i = 0; i < 64; i++) if (cfg_q[i*8 +: 8] !== model[i]) bad = 1'b1;
    check(req, {31'd0, bad}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic oe;
    logic [7:0] q;
    rst_n = 1'b0; idle(); bus_addr = '0; bus_din = '0;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check("R9 cfg_q zero", {31'd0, (cfg_q == '0)}, 32'd1);
    do_read(1'b0, 6'd63, oe, q);
    check("R9 read zero", {24'd0, q}, 32'd0);

    // Vector table: write each entry with its convention, read back in both
    for (int v = 0; v < NVEC; v++) begin
      do_write(VEC[v][14], VEC[v][13:8], VEC[v][7:0]);
      model[VEC[v][13:8]] = VEC[v][7:0];
      do_read(1'b0, VEC[v][13:8], oe, q);
      check(VEC[v][14] ? "R5 split readback" : "R4 split readback", {24'd0, q}, {24'd0, VEC[v][7:0]});
      do_read(1'b1, VEC[v][13:8], oe, q);
      check("R5 direction readback", {24'd0, q}, {24'd0, VEC[v][7:0]});
      check("R1 oe on read", {31'd0, oe}, 32'd1);
      check("R10 field position", {24'd0, cfg_q[VEC[v][13:8]*8 +: 8]}, {24'd0, VEC[v][7:0]});
      check_bank("R11 only addressed register");
    end

    // R1 / R2 / R3 sweep of all line combinations on addr 9 (value 0, din 0)
    @(negedge clk); bus_addr = 6'd9; bus_din = 8'h00;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      {bus_cs_n, bus_rd_n, bus_wr_n} = 3'(c);
      #1;
      check(c == 1 ? "R1 oe combination" : "R2 oe combination", {31'd0, bus_oe}, {31'd0, (c == 1)});
      if (c != 1) check("R3 dout quiet", {24'd0, bus_dout}, 32'd0);
    end
    @(negedge clk); idle(); repeat (4) @(negedge clk);
    check_bank("R11 sweep left bank intact");

    // R3 read of a nonzero register drives its value
    @(negedge clk); bus_addr = 6'd1; bus_rd_n = 1'b0; bus_cs_n = 1'b0; #1;
    check("R3 dout value", {24'd0, bus_dout}, 32'h3C);
    // R3 release when select returns high
    @(negedge clk); bus_cs_n = 1'b1; #1;
    check("R3 release", {23'd0, bus_oe, bus_dout}, 32'd0);
    @(negedge clk); idle();

    // R7 write line low without select
    @(negedge clk); bus_addr = 6'd20; bus_din = 8'h99; bus_wr_n = 1'b0;
    repeat (6) @(negedge clk); idle(); repeat (4) @(negedge clk);
    check("R7 no select no write", {24'd0, cfg_q[20*8 +: 8]}, 32'd0);
    check_bank("R7 bank intact");

    // R8 long read leaves bank unchanged
    @(negedge clk); bus_addr = 6'd0; bus_din = 8'h11; bus_rd_n = 1'b0; bus_cs_n = 1'b0;
    repeat (6) @(negedge clk); idle(); repeat (4) @(negedge clk);
    check_bank("R8 read writes nothing");

    // R6 changes after the hold window are ignored
    @(negedge clk); bus_addr = 6'd10; bus_din = 8'h5A; bus_wr_n = 1'b0;
    @(negedge clk); bus_cs_n = 1'b0;
    repeat (3) @(negedge clk); bus_cs_n = 1'b1; bus_wr_n = 1'b1;
    repeat (2) @(negedge clk); bus_addr = 6'd11; bus_din = 8'hEE;
    repeat (4) @(negedge clk);
    model[10] = 8'h5A;
    check("R6 captured data", {24'd0, cfg_q[10*8 +: 8]}, 32'h5A);
    check("R6 late address ignored", {24'd0, cfg_q[11*8 +: 8]}, 32'd0);

    // R11 overwrite commits the new value once
    do_write(1'b1, 6'd10, 8'h00);
    model[10] = 8'h00;
    check_bank("R11 overwrite");

    // R9 reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset clears bank", {31'd0, (cfg_q == '0)}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule